// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit records the value of a free-running timer when a chosen event shows up on an external input pin. A 4-bit mode field selects the event. It can be any falling edge, any rising edge, every fourth rising edge, or every sixteenth rising edge. The pin passes through a two-flop synchroniser and then an edge detector. For the prescaled modes the edges then go to a small edge counter. On each qualified event the timer value goes into a capture register.

Every capture sets a sticky interrupt flag, which stays set until software clears it with a strobe. A read strobe marks the held value as consumed. If a new capture replaces a value that was never read, an overrun status bit is set. The edge counter is cleared only when the unit is off, when it is outside capture mode, or at reset. A direct switch between the two prescaled settings keeps whatever count has built up.

Top module: `tcap_unit`

## Requirements
- R1: Let a pin level change be driven just after rising clock edge E0. The capture register then holds, just after edge E0+3, the timer value that was present between edges E0+2 and E0+3. The pin goes through two synchroniser flops, and edge detection compares against one further flop.
- R2: With mode 4'b0100, every falling edge of the pin causes a capture and rising edges cause none.
- R3: With mode 4'b0101, every rising edge of the pin causes a capture and falling edges cause none.
- R4: With mode 4'b0110, a capture happens on every fourth rising edge counted by the edge counter. Counting starts at zero after the counter is cleared.
- R5: With mode 4'b0111, a capture happens on every sixteenth rising edge counted by the edge counter.
- R6: Mode 4'b0000 is off. Any code whose upper two bits are not 2'b01 is outside capture mode. In either case no capture happens and the edge counter is held at zero.
- R7: A direct change between modes 4'b0110 and 4'b0111 does not clear the edge counter. After two counted edges in 4'b0110, the first capture in 4'b0111 comes on the 14th rising edge.
- R8: The flag is set by each capture and stays set until the flag-clear strobe is high. If a capture and the flag-clear strobe occur in the same cycle, the flag ends up set.
- R9: A capture overwrites any earlier value. The overrun bit is set when a capture overwrites a value that no read strobe has consumed. A read strobe in the same cycle as the capture counts as consuming the old value. The flag-clear strobe also clears the overrun bit.
- R10: After reset, the capture register is zero and the flag and overrun bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Current timer count |
| pin_in | input | 1 | Asynchronous event pin |
| mode | input | 4 | Event selection code |
| rd_strobe | input | 1 | Marks the captured value as read |
| clr_flag | input | 1 | Clears the flag and the overrun bit |
| cap_value | output | 16 | Capture register |
| cap_flag | output | 1 | Sticky capture interrupt flag |
| cap_overrun | output | 1 | Unread value was overwritten |

## Verification
A capture and a flag clear can land in the same cycle, and so can a capture and a read. The bench times the flag-clear strobe to the cycle in which the synchronised edge is detected. It then requires the flag to remain set afterwards. In a separate case it pairs a read strobe with a second capture, and then checks that the overrun bit stays low while a capture with no read before it sets the bit.

// File: rtl/tcap_unit.sv
module tcap_unit #(
  parameter int TW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          pin_in,
  input  logic [3:0]    mode,
  input  logic          rd_strobe,
  input  logic          clr_flag,
  output logic [TW-1:0] cap_value,
  output logic          cap_flag,
  output logic          cap_overrun
);
  localparam logic [3:0] M_FALL = 4'b0100;
  localparam logic [3:0] M_RISE = 4'b0101;
  localparam logic [3:0] M_DIV4 = 4'b0110;
  localparam logic [3:0] M_DIVN = 4'b0111;

  logic          sy1, sy2, sy_d;
  logic [PW-1:0] pcnt;
  logic          unread;
  logic          evt;

  wire act  = (mode[3:2] == 2'b01);
  wire pre  = (mode[3:1] == 3'b011);
  wire rise = sy2 & ~sy_d;
  wire fall = ~sy2 & sy_d;

  always_comb begin
    case (mode)
      M_FALL:  evt = fall;
      M_RISE:  evt = rise;
      M_DIV4:  evt = rise && (pcnt[1:0] == 2'b11);
      M_DIVN:  evt = rise && (pcnt == {PW{1'b1}});
      default: evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1  <= 1'b0;
      sy2  <= 1'b0;
      sy_d <= 1'b0;
    end else begin
      sy1  <= pin_in;
      sy2  <= sy1;
      sy_d <= sy2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !act) pcnt <= '0;
    else if (pre && rise) pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_value   <= '0;
      cap_flag    <= 1'b0;
      cap_overrun <= 1'b0;
      unread      <= 1'b0;
    end else begin
      if (evt) cap_value <= timer_val;
      if (evt) cap_flag <= 1'b1;
      else if (clr_flag) cap_flag <= 1'b0;
      if (evt && unread && !rd_strobe) cap_overrun <= 1'b1;
      else if (clr_flag) cap_overrun <= 1'b0;
      if (evt) unread <= 1'b1;
      else if (rd_strobe) unread <= 1'b0;
    end
  end
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          clr_flag,
  input logic [TW-1:0] cap_value,
  input logic          cap_flag,
  input logic          cap_overrun
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !clr_flag) |=> cap_flag); // R8
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01 && clr_flag) |=> !cap_flag); // R6
  AST_INACTIVE_HOLDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |=> $stable(cap_value)); // R6
  AST_OVERRUN_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_overrun) |-> cap_flag); // R9
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && cap_overrun && mode[3:2] != 2'b01) |=> !cap_overrun); // R9
endmodule

bind tcap_unit tcap_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .clr_flag(clr_flag),
  .cap_value(cap_value), .cap_flag(cap_flag), .cap_overrun(cap_overrun)
);

// File: tb/tcap_unit_bench.sv
module tcap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr;
  logic        pin = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        rd = 1'b0, clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag, cap_overrun;
  int tests = 0, fails = 0;
  logic [15:0] v;

  always #4 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) tmr <= 16'h1200;
    else tmr <= tmr + 16'd3;

  tcap_unit u_tcap_unit (
    .clk(clk), .rst_n(rst_n), .timer_val(tmr), .pin_in(pin), .mode(mode),
    .rd_strobe(rd), .clr_flag(clr), .cap_value(cap_value),
    .cap_flag(cap_flag), .cap_overrun(cap_overrun)
  );

  // {mode, pin, capture expected}
  localparam logic [5:0] VEC [16] = '{
    {4'b0000,1'b0,1'b0}, {4'b0101,1'b1,1'b1}, {4'b0101,1'b0,1'b0},
    {4'b0100,1'b1,1'b0}, {4'b0100,1'b0,1'b1}, {4'b0110,1'b1,1'b0},
    {4'b0110,1'b0,1'b0}, {4'b0110,1'b1,1'b0}, {4'b0110,1'b0,1'b0},
    {4'b0110,1'b1,1'b0}, {4'b0110,1'b0,1'b0}, {4'b0110,1'b1,1'b1},
    {4'b0110,1'b0,1'b0}, {4'b0000,1'b0,1'b0}, {4'b0011,1'b1,1'b0},
    {4'b0011,1'b0,1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] m, input logic lvl);
    @(negedge clk);
    mode = m; pin = lvl; v = tmr;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); rd = 1'b1; clr = 1'b1;
    @(negedge clk); rd = 1'b0; clr = 1'b0;
  endtask

  task automatic pulses(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      step(m, 1'b1);
      step(m, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 value", cap_value, 16'h0000);
    check("R10 flag", {15'd0, cap_flag}, 16'd0);
    check("R10 overrun", {15'd0, cap_overrun}, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][5:2], VEC[i][1]);
      check($sformatf("R2 R3 R4 R6 vec%0d flag", i), {15'd0, cap_flag}, {15'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        check($sformatf("R1 vec%0d value", i), cap_value, v + 16'd6);
        repeat (5) @(negedge clk);
        check("R8 flag sticky", {15'd0, cap_flag}, 16'd1);
        clear_all();
        check("R8 flag cleared", {15'd0, cap_flag}, 16'd0);
      end
    end

    // R5: sixteenth rising edge after off
    step(4'b0000, 1'b0);
    pulses(4'b0111, 15);
    check("R5 no capture on 15 edges", {15'd0, cap_flag}, 16'd0);
    step(4'b0111, 1'b1);
    check("R5 capture on 16th", {15'd0, cap_flag}, 16'd1);
    check("R5 value", cap_value, v + 16'd6);
    clear_all();

    // R6: off clears a partial count
    step(4'b0000, 1'b0);
    pulses(4'b0110, 2);
    step(4'b0000, 1'b0);
    pulses(4'b0110, 3);
    check("R6 count cleared by off", {15'd0, cap_flag}, 16'd0);
    step(4'b0110, 1'b1);
    check("R6 fourth edge after off", {15'd0, cap_flag}, 16'd1);
    step(4'b0110, 1'b0);
    clear_all();

    // R7: stale count kept across prescale switch
    step(4'b0000, 1'b0);
    pulses(4'b0110, 2);
    pulses(4'b0111, 13);
    check("R7 no capture on 13 edges", {15'd0, cap_flag}, 16'd0);
    step(4'b0111, 1'b1);
    check("R7 capture on 14th", {15'd0, cap_flag}, 16'd1);
    step(4'b0111, 1'b0);
    clear_all();

    // R9: overwrite without read
    step(4'b0101, 1'b1);
    step(4'b0101, 1'b0);
    check("R9 no overrun on first", {15'd0, cap_overrun}, 16'd0);
    step(4'b0101, 1'b1);
    check("R9 overrun set", {15'd0, cap_overrun}, 16'd1);
    check("R9 newer value kept", cap_value, v + 16'd6);
    step(4'b0101, 1'b0);
    clear_all();
    check("R9 overrun cleared", {15'd0, cap_overrun}, 16'd0);

    // R9: read in the same cycle as a capture
    step(4'b0101, 1'b1);
    step(4'b0101, 1'b0);
    @(negedge clk); pin = 1'b1;
    repeat (2) @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
    check("R9 same-cycle read no overrun", {15'd0, cap_overrun}, 16'd0);
    clear_all();
    step(4'b0101, 1'b0);
    clear_all();

    // R8: clear in the capture cycle
    @(negedge clk); pin = 1'b1;
    repeat (2) @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    check("R8 capture beats clear", {15'd0, cap_flag}, 16'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule